// File: doc/BRIEF.md
# Dual Timer Register Window

This block is a 4 KB bus-mapped register window that holds two countdown timer channels. Each channel gets its own 32-byte region. Channel 0 sits at the bottom of the window, and channel 1 sits directly above it. An access to channel 1 is rebased so that the channel sees an offset measured from the start of its own region. Near the top of the window there is a read-only table of eight identification bytes. The integration-test offsets read as zero, and so does every other unmapped offset. Writes that miss both channel regions have no effect.

Each channel counts down on a tick enable that belongs to that channel only, so the two channels can run at unrelated rates. When a channel expires, it sets a pending flag. The flag is gated by the channel's interrupt enable. The two gated lines are OR-ed onto a single interrupt output.

The bus side uses plain strobes with no back-pressure. A write is accepted on any cycle where `wr_en` is high. A read is accepted on any cycle where `rd_en` is high, and its result is registered. `rdata` keeps its value until the next read.

Top module: `dual_timer_window`

Channel registers, as byte offsets inside a channel region:
- 0x00 control: bit0 run, bit1 periodic, bit2 single-shot, bit3 32-bit, bit4 interrupt enable.
- 0x04 load: writing it sets the limit and the count. Reading it returns the limit.
- 0x08 next limit: writing it sets the limit only. Reading it returns the limit.
- 0x0C count: read-only.
- 0x10 interrupt clear: write-only.
- 0x14 raw pending.
- 0x18 masked pending.

## Requirements
- R1: After reset, `rdata` is 0 and `irq` is 0. Each channel's control register reads 0x10, which means interrupt enable is set and the channel is stopped. Each channel's count reads 0.
- R2: Byte addresses 0x00 to 0x1F access channel 0.
- R3: Byte addresses 0x20 to 0x3F access channel 1, which sees the address minus 0x20. An access to one channel leaves the other channel unchanged.
- R4: Reads at 0xFE0, 0xFE4, and so on up to 0xFFC return 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order. Each byte is zero-extended into bits 7:0.
- R5: Reads at 0xF00, at 0xF04 and at every other offset outside the channels and the identification table return 0.
- R6: A write to any address at or above 0x40 changes neither channel's registers nor the identification table.
- R7: Read data appears on the cycle after the edge at which `rd_en` is sampled high. It holds its value while `rd_en` is low.
- R8: `irq` is the OR of the two channels' masked interrupt lines. It is high while either line is high.
- R9: A channel counts only on edges where its own `tick_en` bit is high and its run bit is set.
- R10: In periodic mode, a tick at count 0 sets the pending flag and reloads the count from the limit. Any other tick decrements the count.
- R11: In single-shot mode, the expiring tick reloads the limit and clears the run bit. After that, further ticks leave the count unchanged.
- R12: The raw pending register shows the flag regardless of interrupt enable. The masked register and `irq` show it only while interrupt enable is set.
- R13: A write to the interrupt-clear offset clears the pending flag.
- R14: In free-running 16-bit mode (periodic and single-shot both clear, bit3 clear), the expiring tick reloads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte address within the window |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| tick_en | input | 2 | Per-channel count enable, bit i for channel i |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | OR of the channel interrupts |

## Verification
A write or a tick presented before a rising edge takes effect at that edge. `irq` follows combinationally from the registers that were just updated, so the bench samples it on the falling edge after the strobe. A read result lands in `rdata` one edge after `rd_en` is sampled. Each read task therefore drives its strobe on a falling edge, lowers it on the next falling edge and samples there. One check looks at `rdata` before that edge to confirm that it still holds the old value. Checks on tick counts drive `tick_en` for exactly N rising edges and then compare the count against a value worked out by hand.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int NUM_CH    = 2;
  localparam int REGION_W  = 5;   // 32-byte channel region
  localparam int NARROW_W  = 16;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_LOAD  = 3'd1,
    SEL_NEXT  = 3'd2,
    SEL_COUNT = 3'd3,
    SEL_ICLR  = 3'd4,
    SEL_RAW   = 3'd5,
    SEL_MSK   = 3'd6,
    SEL_NONE  = 3'd7
  } sel_e;

  typedef struct packed {
    logic ie;
    logic wide;
    logic single;
    logic periodic;
    logic run;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{ie: 1'b1, default: 1'b0};

  function automatic logic [7:0] ident_byte(input logic [2:0] idx);
    case (idx)
      3'd0: ident_byte = 8'h04;
      3'd1: ident_byte = 8'h18;
      3'd2: ident_byte = 8'h14;
      3'd3: ident_byte = 8'h00;
      3'd4: ident_byte = 8'h0D;
      3'd5: ident_byte = 8'hF0;
      3'd6: ident_byte = 8'h05;
      default: ident_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dtw_decode.sv
module dtw_decode
  import dtw_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                ch_hit,
  output logic [$clog2(NUM_CH)-1:0] ch_idx,
  output logic [2:0]          word_sel,
  output logic                id_hit,
  output logic [2:0]          id_idx
);
  localparam int IDX_W  = $clog2(NUM_CH);
  localparam int UPPER_W = ADDR_W - REGION_W;
  localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'(12'hFE0);

  logic [UPPER_W-1:0] region;

  always_comb begin
    region   = addr[ADDR_W-1:REGION_W];
    ch_hit   = (region < UPPER_W'(NUM_CH));
    ch_idx   = addr[REGION_W +: IDX_W];
    word_sel = addr[REGION_W-1:2];
    id_hit   = (addr[ADDR_W-1:REGION_W] == ID_BASE[ADDR_W-1:REGION_W]);
    id_idx   = addr[4:2];
  end
endmodule

// File: rtl/dtw_channel.sv
module dtw_channel
  import dtw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [2:0]        word_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int CTRL_W = $bits(ctrl_t);
  localparam logic [DATA_W-1:0] NARROW_MAX = DATA_W'({NARROW_W{1'b1}});

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] limit_q, count_q, wrap_val, dec_val;
  logic              pend_q, expire;
  sel_e              sel;

  always_comb begin
    sel      = sel_e'(word_sel);
    expire   = tick && ctrl_q.run && (count_q == '0);
    if (ctrl_q.periodic || ctrl_q.single) wrap_val = limit_q;
    else if (ctrl_q.wide)                 wrap_val = '1;
    else                                  wrap_val = NARROW_MAX;
    dec_val  = ctrl_q.wide ? (count_q - 1'b1)
                           : DATA_W'(count_q[NARROW_W-1:0] - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      limit_q <= '0;
      count_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_en && sel == SEL_CTRL)  ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      else if (expire && ctrl_q.single) ctrl_q.run <= 1'b0;

      if (wr_en && (sel == SEL_LOAD || sel == SEL_NEXT)) limit_q <= wdata;

      if (wr_en && sel == SEL_LOAD)       count_q <= wdata;
      else if (tick && ctrl_q.run)        count_q <= expire ? wrap_val : dec_val;

      if (expire)                         pend_q <= 1'b1;
      else if (wr_en && sel == SEL_ICLR)  pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL:  rdata = DATA_W'(ctrl_q);
      SEL_LOAD,
      SEL_NEXT:  rdata = limit_q;
      SEL_COUNT: rdata = count_q;
      SEL_RAW:   rdata = DATA_W'(pend_q);
      SEL_MSK:   rdata = DATA_W'(pend_q && ctrl_q.ie);
      default:   rdata = '0;
    endcase
    irq = pend_q && ctrl_q.ie;
  end
endmodule

// File: rtl/dual_timer_window.sv
module dual_timer_window
  import dtw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [NUM_CH-1:0] tick_en,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int IDX_W = $clog2(NUM_CH);

  logic              ch_hit, id_hit;
  logic [IDX_W-1:0]  ch_idx;
  logic [2:0]        word_sel, id_idx;
  logic [DATA_W-1:0] ch_rd [NUM_CH];
  logic [NUM_CH-1:0] ch_irq;
  logic [DATA_W-1:0] rd_next;

  dtw_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .ch_hit(ch_hit), .ch_idx(ch_idx),
    .word_sel(word_sel), .id_hit(id_hit), .id_idx(id_idx)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dtw_channel #(.DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick_en[i]),
      .wr_en(wr_en && ch_hit && (ch_idx == IDX_W'(i))),
      .word_sel(word_sel), .wdata(wdata),
      .rdata(ch_rd[i]), .irq(ch_irq[i])
    );
  end

  always_comb begin
    if (ch_hit)      rd_next = ch_rd[ch_idx];
    else if (id_hit) rd_next = DATA_W'(ident_byte(id_idx));
    else             rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  assign irq = |ch_irq;
endmodule

// File: rtl/dual_timer_window_chk.sv
module dual_timer_window_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        tick_en,
  input logic [DATA_W-1:0] rdata,
  input logic              irq
);
  // R7: read data only moves after a sampled read strobe
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R5: test-register offsets read zero
  p_test_regs_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == ADDR_W'(12'hF00) || addr == ADDR_W'(12'hF04)) |=> rdata == '0);

  // R4: identification bytes are zero-extended
  p_ident_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr[ADDR_W-1:5] == 7'h7F) |=> rdata[DATA_W-1:8] == '0);

  // R4: first identification byte
  p_ident_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == ADDR_W'(12'hFE0)) |=> rdata == DATA_W'(8'h04));

  // R8: the interrupt only rises after a tick or a write
  p_irq_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_en) || $past(|tick_en));

  // R13: the interrupt only falls after a write
  p_irq_fall_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en));
endmodule

bind dual_timer_window dual_timer_window_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .tick_en(tick_en), .rdata(rdata), .irq(irq)
);

// File: tb/dual_timer_window_tb.sv
module dual_timer_window_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  tick_en = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  dual_timer_window u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .tick_en(tick_en), .rdata(rdata), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic read_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic ticks(input logic [1:0] m, input int n);
    @(negedge clk);
    tick_en = m;
    repeat (n) @(negedge clk);
    tick_en = '0;
  endtask

  task automatic t_reset();
    check("R1 rdata", rdata, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    read_check("R1 ch0 ctrl", 12'h000, 32'h10);
    read_check("R1 ch1 ctrl", 12'h020, 32'h10);
    read_check("R1 ch1 count", 12'h02C, 32'h0);
  endtask

  task automatic t_regions();
    bus_write(12'h004, 32'hA5A5_0001);
    bus_write(12'h028, 32'h1234_5678);
    read_check("R2 ch0 load", 12'h004, 32'hA5A5_0001);
    read_check("R2 ch0 count", 12'h00C, 32'hA5A5_0001);
    read_check("R3 ch1 limit", 12'h024, 32'h1234_5678);
    read_check("R3 ch1 count untouched", 12'h02C, 32'h0);
    read_check("R3 ch0 limit untouched", 12'h008, 32'hA5A5_0001);
  endtask

  task automatic t_ignored_writes();
    bus_write(12'h040, 32'hFFFF_FFFF);
    bus_write(12'h044, 32'hFFFF_FFFF);
    bus_write(12'h800, 32'hFFFF_FFFF);
    bus_write(12'hF00, 32'hFFFF_FFFF);
    bus_write(12'hFE4, 32'hFFFF_FFFF);
    read_check("R6 ch0 limit", 12'h004, 32'hA5A5_0001);
    read_check("R6 ch1 limit", 12'h024, 32'h1234_5678);
    read_check("R6 ident", 12'hFE4, 32'h18);
  endtask

  task automatic t_ident();
    logic [7:0] exp_id [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++)
      read_check("R4 ident byte", 12'hFE0 + 12'(4*i), {24'b0, exp_id[i]});
  endtask

  task automatic t_unmapped();
    read_check("R5 test ctrl", 12'hF00, 32'h0);
    read_check("R5 test out", 12'hF04, 32'h0);
    read_check("R5 gap 0x40", 12'h040, 32'h0);
    read_check("R5 gap 0x800", 12'h800, 32'h0);
    read_check("R5 gap 0xFDC", 12'hFDC, 32'h0);
  endtask

  task automatic t_read_timing();
    logic [31:0] v;
    bus_read(12'h004, v);
    @(negedge clk);
    addr = 12'h024; rd_en = 1'b1;
    #1 check("R7 old data before edge", rdata, 32'hA5A5_0001);
    @(negedge clk);
    rd_en = 1'b0;
    check("R7 new data after edge", rdata, 32'h1234_5678);
    addr = 12'hFE0;
    repeat (3) @(negedge clk);
    check("R7 hold without strobe", rdata, 32'h1234_5678);
  endtask

  task automatic t_periodic();
    bus_write(12'h000, 32'h10);
    bus_write(12'h004, 32'd3);
    bus_write(12'h000, 32'h1B);
    ticks(2'b01, 3);
    read_check("R10 count at zero", 12'h00C, 32'd0);
    check("R10 no irq yet", {31'b0, irq}, 32'h0);
    ticks(2'b01, 1);
    check("R10 irq on expiry", {31'b0, irq}, 32'h1);
    read_check("R10 reload", 12'h00C, 32'd3);
    bus_write(12'h000, 32'h10);
    bus_write(12'h010, 32'h0);
  endtask

  task automatic t_tick_select();
    bus_write(12'h004, 32'd10);
    bus_write(12'h024, 32'd10);
    bus_write(12'h000, 32'h1B);
    bus_write(12'h020, 32'h1B);
    ticks(2'b01, 2);
    read_check("R9 ch0 counted", 12'h00C, 32'd8);
    read_check("R9 ch1 idle", 12'h02C, 32'd10);
    ticks(2'b10, 1);
    read_check("R9 ch0 idle", 12'h00C, 32'd8);
    read_check("R9 ch1 counted", 12'h02C, 32'd9);
    bus_write(12'h000, 32'h1A);
    ticks(2'b01, 2);
    read_check("R9 stopped channel", 12'h00C, 32'd8);
    bus_write(12'h000, 32'h10);
    bus_write(12'h020, 32'h10);
  endtask

  task automatic t_single();
    bus_write(12'h024, 32'd1);
    bus_write(12'h020, 32'h1D);
    ticks(2'b10, 2);
    read_check("R11 reload", 12'h02C, 32'd1);
    read_check("R11 run cleared", 12'h020, 32'h1C);
    check("R8 ch1 alone drives irq", {31'b0, irq}, 32'h1);
    ticks(2'b10, 2);
    read_check("R11 no further count", 12'h02C, 32'd1);
    bus_write(12'h030, 32'h0);
    check("R13 clear drops irq", {31'b0, irq}, 32'h0);
    read_check("R13 raw cleared", 12'h034, 32'h0);
  endtask

  task automatic t_mask();
    bus_write(12'h004, 32'd0);
    bus_write(12'h000, 32'h03);
    ticks(2'b01, 1);
    bus_write(12'h000, 32'h02);
    read_check("R12 raw set", 12'h014, 32'h1);
    read_check("R12 masked zero", 12'h018, 32'h0);
    check("R12 irq masked", {31'b0, irq}, 32'h0);
    bus_write(12'h000, 32'h12);
    check("R12 irq unmasked", {31'b0, irq}, 32'h1);
    read_check("R12 masked set", 12'h018, 32'h1);
    bus_write(12'h010, 32'h0);
    check("R13 clear irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_merge();
    bus_write(12'h004, 32'd0);
    bus_write(12'h024, 32'd0);
    bus_write(12'h000, 32'h13);
    bus_write(12'h020, 32'h13);
    ticks(2'b11, 1);
    bus_write(12'h000, 32'h12);
    bus_write(12'h020, 32'h12);
    check("R8 both pending", {31'b0, irq}, 32'h1);
    bus_write(12'h010, 32'h0);
    check("R8 ch1 still pending", {31'b0, irq}, 32'h1);
    bus_write(12'h030, 32'h0);
    check("R8 none pending", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_free_run();
    bus_write(12'h024, 32'd0);
    bus_write(12'h020, 32'h11);
    ticks(2'b10, 1);
    read_check("R14 wrap to 16-bit max", 12'h02C, 32'h0000_FFFF);
    read_check("R14 pending", 12'h034, 32'h1);
    ticks(2'b10, 1);
    read_check("R14 decrement", 12'h02C, 32'h0000_FFFE);
    bus_write(12'h020, 32'h10);
    bus_write(12'h030, 32'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regions();
    t_ignored_writes();
    t_ident();
    t_unmapped();
    t_read_timing();
    t_periodic();
    t_tick_select();
    t_single();
    t_mask();
    t_merge();
    t_free_run();
    summary();
  end
endmodule